// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the operating state of a DRAM protocol controller. Software issues a state command by pulsing a write strobe with a 3-bit code. It then polls a status word until the intended state is shown. The stable states are initialization, configuration, access and low power. Every move between configuration, access and low power passes through a visible request state. That request state lasts `REQ_CYCLES` clock cycles before the target state is entered.

Low power can be entered in two ways. Software can command it, or a hardware trigger can request it while a hardware low-power enable is set. The status word records which of the two caused the entry. When hardware caused the entry, the block also leaves low power by itself once the trigger drops. Software therefore has no need to wake it. Leaving low power always lands in access, so software that wants configuration must first wake the controller and then send the configuration command.

Top module: `memctl_opstate`

## Requirements
- R1: After reset, and whenever reset is asserted, the status word reads 0x00: the initialization state with a trigger field of 0.
- R2: The status word is laid out as follows. Bits [2:0] carry the state code: 0 init, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request. Bits [6:4] carry the trigger field: 0 none, 1 hardware, 2 software. Bits 7 and 3 are always 0.
- R3: Command code 1 (configure), written in the init or the access state, moves the block to config-request on the next edge. The block shows config-request for exactly `REQ_CYCLES` cycles and then shows config.
- R4: Command code 2 (go), written in the config state, moves the block to access-request for `REQ_CYCLES` cycles and then to access.
- R5: Command code 3 (sleep), written in the access state, moves the block to low-power-entry-request for `REQ_CYCLES` cycles and then to low-power. The trigger field is set to 2 from the entry request onward.
- R6: In access, with no legal command written, `hw_lp_en` and `hw_lp_req` both high start a low-power entry with a trigger field of 1. With `hw_lp_en` low, `hw_lp_req` has no effect.
- R7: Command code 4 (wakeup), written in low-power, moves the block to low-power-exit-request for `REQ_CYCLES` cycles and then to access. The trigger field returns to 0 when access is reached. A configure command in low-power is ignored.
- R8: In low-power with a trigger field of 1, `hw_lp_req` low starts the exit sequence without any command. With a trigger field of 2, the block stays in low-power until a wakeup command arrives.
- R9: A command written during any request state, a command that is not legal in the current stable state, and codes 5 to 7 are all ignored, and the state is unchanged.
- R10: Command code 0 (init), written in the config state, returns the block to init on the next edge.
- R11: When a legal command and the hardware trigger arrive in the same access cycle, the command wins and the trigger field records 2 for a sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one cycle per command |
| cmd_code | input | 3 | State command code, sampled when `cmd_we` is high |
| hw_lp_en | input | 1 | Enables the hardware low-power trigger |
| hw_lp_req | input | 1 | Hardware low-power request |
| status | output | 8 | State code in [2:0], trigger source in [6:4] |

## Verification
A wrong internal state always shows up on `status[2:0]` at the first sample after the clock edge that caused it. No state is hidden behind the status word. If the request timer loads or counts wrongly, the target state appears one or more cycles early or late. Because the bench checks every cycle of each request window, that error is caught in the first cycle it occurs. If the trigger register is mishandled, `status[6:4]` is wrong from the entry request onward, or it stays non-zero after access is reached. A wrongly decoded command shows up as a state change on the next edge, where the bench expects none.

// File: rtl/memctl_opstate_pkg.sv
package memctl_opstate_pkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_CFG     = 3'd1,
    ST_CFG_REQ = 3'd2,
    ST_ACC     = 3'd3,
    ST_ACC_REQ = 3'd4,
    ST_LP      = 3'd5,
    ST_LP_ENT  = 3'd6,
    ST_LP_EXIT = 3'd7
  } opstate_e;

  localparam logic [2:0] CMD_INIT  = 3'd0;
  localparam logic [2:0] CMD_CFG   = 3'd1;
  localparam logic [2:0] CMD_GO    = 3'd2;
  localparam logic [2:0] CMD_SLEEP = 3'd3;
  localparam logic [2:0] CMD_WAKE  = 3'd4;

  localparam logic [2:0] TRIG_NONE = 3'd0;
  localparam logic [2:0] TRIG_HW   = 3'd1;
  localparam logic [2:0] TRIG_SW   = 3'd2;

  function automatic logic is_req_state(opstate_e s);
    return (s == ST_CFG_REQ) || (s == ST_ACC_REQ) ||
           (s == ST_LP_ENT)  || (s == ST_LP_EXIT);
  endfunction

  // Stable state that a request state lands in
  function automatic opstate_e req_target(opstate_e s);
    case (s)
      ST_CFG_REQ: return ST_CFG;
      ST_ACC_REQ: return ST_ACC;
      ST_LP_ENT:  return ST_LP;
      ST_LP_EXIT: return ST_ACC;
      default:    return s;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(opstate_e s, logic [2:0] trig);
    return {1'b0, trig, 1'b0, s};
  endfunction

endpackage

// File: rtl/opstate_cmd_decode.sv
module opstate_cmd_decode
  import memctl_opstate_pkg::*;
(
  input  opstate_e   state,
  input  logic [2:0] trig,
  input  logic       cmd_we,
  input  logic [2:0] cmd_code,
  input  logic       hw_lp_en,
  input  logic       hw_lp_req,
  output logic       take,
  output opstate_e   nxt,
  output logic       set_trig,
  output logic [2:0] trig_val
);

  always_comb begin
    take     = 1'b0;
    nxt      = state;
    set_trig = 1'b0;
    trig_val = TRIG_NONE;
    case (state)
      ST_INIT: begin
        if (cmd_we && cmd_code == CMD_CFG) begin
          take = 1'b1;
          nxt  = ST_CFG_REQ;
        end
      end
      ST_CFG: begin
        if (cmd_we && cmd_code == CMD_GO) begin
          take = 1'b1;
          nxt  = ST_ACC_REQ;
        end else if (cmd_we && cmd_code == CMD_INIT) begin
          take = 1'b1;
          nxt  = ST_INIT;
        end
      end
      ST_ACC: begin
        if (cmd_we && cmd_code == CMD_CFG) begin
          take = 1'b1;
          nxt  = ST_CFG_REQ;
        end else if (cmd_we && cmd_code == CMD_SLEEP) begin
          take     = 1'b1;
          nxt      = ST_LP_ENT;
          set_trig = 1'b1;
          trig_val = TRIG_SW;
        end else if (hw_lp_en && hw_lp_req) begin
          take     = 1'b1;
          nxt      = ST_LP_ENT;
          set_trig = 1'b1;
          trig_val = TRIG_HW;
        end
      end
      ST_LP: begin
        if (cmd_we && cmd_code == CMD_WAKE) begin
          take = 1'b1;
          nxt  = ST_LP_EXIT;
        end else if (trig == TRIG_HW && !hw_lp_req) begin
          take = 1'b1;
          nxt  = ST_LP_EXIT;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/opstate_req_timer.sv
module opstate_req_timer #(
  parameter int REQ_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic active,
  output logic done
);

  localparam int CW = (REQ_CYCLES > 1) ? $clog2(REQ_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(REQ_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= LOAD_VAL;
    else if (active && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = active && (cnt == '0);

endmodule

// File: rtl/memctl_opstate.sv
module memctl_opstate
  import memctl_opstate_pkg::*;
#(
  parameter int REQ_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [2:0] cmd_code,
  input  logic       hw_lp_en,
  input  logic       hw_lp_req,
  output logic [7:0] status
);

  opstate_e   state;
  opstate_e   nxt;
  logic [2:0] trig;
  logic [2:0] trig_val;
  logic       take;
  logic       set_trig;
  logic       in_req;
  logic       tmr_done;
  logic       tmr_load;

  assign in_req   = is_req_state(state);
  assign tmr_load = take && is_req_state(nxt);

  opstate_cmd_decode u_dec (
    .state     (state),
    .trig      (trig),
    .cmd_we    (cmd_we),
    .cmd_code  (cmd_code),
    .hw_lp_en  (hw_lp_en),
    .hw_lp_req (hw_lp_req),
    .take      (take),
    .nxt       (nxt),
    .set_trig  (set_trig),
    .trig_val  (trig_val)
  );

  opstate_req_timer #(.REQ_CYCLES(REQ_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .active (in_req),
    .done   (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_INIT;
      trig  <= TRIG_NONE;
    end else begin
      if (in_req && tmr_done) state <= req_target(state);
      else if (take)          state <= nxt;
      if (set_trig)                                trig <= trig_val;
      else if (state == ST_LP_EXIT && tmr_done)    trig <= TRIG_NONE;
    end
  end

  assign status = pack_status(state, trig);

  // R9: a request state holds until its timer expires
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && !tmr_done) |=> (state == $past(state)));

  // R3: an expired request lands in its target
  a_r3_req_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && tmr_done) |=> (state == req_target($past(state))));

  // R9: a stable state without an accepted command does not move
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_req && !take) |=> $stable(state));

  // R2: a trigger source is shown only around low power
  a_r2_trig_only_lp: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != TRIG_NONE) |-> (state == ST_LP_ENT || state == ST_LP || state == ST_LP_EXIT));

  // R4: access is only ever entered from a request state
  a_r4_access_via_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC && $past(state) != ST_ACC) |->
      ($past(state) == ST_ACC_REQ || $past(state) == ST_LP_EXIT));

endmodule

// File: tb/tb_memctl_opstate.sv
`timescale 1ns/100ps
module tb_memctl_opstate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       hw_lp_en = 1'b0;
  logic       hw_lp_req = 1'b0;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  memctl_opstate #(.REQ_CYCLES(3)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .hw_lp_en(hw_lp_en), .hw_lp_req(hw_lp_req), .status(status)
  );

  // {we, cmd[2:0], hw_en, hw_req, expected status[7:0], requirement[7:0]}
  localparam int NV = 46;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,3'd0,1'b0,1'b0,8'h00,8'd1},  // R1 idle in init
    {1'b1,3'd2,1'b0,1'b0,8'h00,8'd9},  // R9 go illegal in init
    {1'b1,3'd1,1'b0,1'b0,8'h02,8'd3},  // R3 configure
    {1'b0,3'd0,1'b0,1'b0,8'h02,8'd3},
    {1'b1,3'd1,1'b0,1'b0,8'h02,8'd9},  // R9 command ignored in request
    {1'b0,3'd0,1'b0,1'b0,8'h01,8'd3},  // R3 config after 3 cycles
    {1'b1,3'd3,1'b0,1'b0,8'h01,8'd9},  // R9 sleep illegal in config
    {1'b1,3'd2,1'b0,1'b0,8'h04,8'd4},  // R4 go
    {1'b0,3'd0,1'b0,1'b0,8'h04,8'd4},
    {1'b0,3'd0,1'b0,1'b0,8'h04,8'd4},
    {1'b0,3'd0,1'b0,1'b0,8'h03,8'd4},  // R4 access
    {1'b1,3'd7,1'b0,1'b0,8'h03,8'd9},  // R9 undefined code
    {1'b0,3'd0,1'b0,1'b1,8'h03,8'd6},  // R6 trigger without enable
    {1'b1,3'd3,1'b0,1'b0,8'h26,8'd5},  // R5 sleep
    {1'b0,3'd0,1'b0,1'b0,8'h26,8'd5},
    {1'b0,3'd0,1'b0,1'b0,8'h26,8'd5},
    {1'b0,3'd0,1'b0,1'b0,8'h25,8'd5},  // R5 low power, sw trigger
    {1'b1,3'd1,1'b0,1'b0,8'h25,8'd7},  // R7 configure ignored in low power
    {1'b1,3'd4,1'b0,1'b0,8'h27,8'd7},  // R7 wakeup
    {1'b0,3'd0,1'b0,1'b0,8'h27,8'd7},
    {1'b0,3'd0,1'b0,1'b0,8'h27,8'd7},
    {1'b0,3'd0,1'b0,1'b0,8'h03,8'd7},  // R7 access, trigger cleared
    {1'b0,3'd0,1'b1,1'b1,8'h16,8'd6},  // R6 hardware entry
    {1'b0,3'd0,1'b1,1'b1,8'h16,8'd6},
    {1'b0,3'd0,1'b1,1'b1,8'h16,8'd6},
    {1'b0,3'd0,1'b1,1'b1,8'h15,8'd6},
    {1'b0,3'd0,1'b1,1'b1,8'h15,8'd8},  // R8 held while trigger high
    {1'b0,3'd0,1'b1,1'b0,8'h17,8'd8},  // R8 self exit
    {1'b0,3'd0,1'b1,1'b0,8'h17,8'd8},
    {1'b0,3'd0,1'b1,1'b0,8'h17,8'd8},
    {1'b0,3'd0,1'b1,1'b0,8'h03,8'd8},
    {1'b1,3'd3,1'b1,1'b1,8'h26,8'd11}, // R11 command beats trigger
    {1'b0,3'd0,1'b1,1'b0,8'h26,8'd11},
    {1'b0,3'd0,1'b1,1'b0,8'h26,8'd11},
    {1'b0,3'd0,1'b1,1'b0,8'h25,8'd11},
    {1'b0,3'd0,1'b1,1'b0,8'h25,8'd8},  // R8 sw entry stays
    {1'b1,3'd4,1'b0,1'b0,8'h27,8'd7},
    {1'b0,3'd0,1'b0,1'b0,8'h27,8'd7},
    {1'b0,3'd0,1'b0,1'b0,8'h27,8'd7},
    {1'b0,3'd0,1'b0,1'b0,8'h03,8'd7},
    {1'b1,3'd1,1'b0,1'b0,8'h02,8'd3},  // R3 configure from access
    {1'b0,3'd0,1'b0,1'b0,8'h02,8'd3},
    {1'b0,3'd0,1'b0,1'b0,8'h02,8'd3},
    {1'b0,3'd0,1'b0,1'b0,8'h01,8'd3},
    {1'b1,3'd0,1'b0,1'b0,8'h00,8'd10}, // R10 init from config
    {1'b0,3'd0,1'b0,1'b0,8'h00,8'd2}   // R2 reserved bits zero
  };

  task automatic check(input logic [7:0] exp, input int req);
    n_chk++;
    if (status !== exp) begin
      n_bad++;
      $display("FAIL R%0d: status actual=%02h expected=%02h", req, status, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] c, input logic en,
                      input logic rq, input logic [7:0] exp, input int req);
    @(negedge clk);
    cmd_we = we; cmd_code = c; hw_lp_en = en; hw_lp_req = rq;
    @(posedge clk);
    #1;
    cmd_we = 1'b0;
    check(exp, req);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL R1: watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(8'h00, 1);                      // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20:18], VEC[i][17], VEC[i][16], VEC[i][15:8], int'(VEC[i][7:0]));
    end
    // R1: reset from low power clears state and trigger
    step(1'b1, 3'd1, 1'b0, 1'b0, 8'h02, 3);
    step(1'b0, 3'd0, 1'b0, 1'b0, 8'h02, 3);
    step(1'b0, 3'd0, 1'b0, 1'b0, 8'h02, 3);
    step(1'b0, 3'd0, 1'b0, 1'b0, 8'h01, 3);
    step(1'b1, 3'd2, 1'b0, 1'b0, 8'h04, 4);
    step(1'b0, 3'd0, 1'b0, 1'b0, 8'h04, 4);
    step(1'b0, 3'd0, 1'b0, 1'b0, 8'h04, 4);
    step(1'b0, 3'd0, 1'b0, 1'b0, 8'h03, 4);
    step(1'b1, 3'd3, 1'b0, 1'b0, 8'h26, 5);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(8'h00, 1);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule